// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block produces the status byte that a parallel NOR flash command engine returns while a program or erase operation is running. Software polls that byte to learn when the operation has finished. Two mechanisms report progress. Bit 6 flips on every status read while an operation is active. Bit 7 shows the complement of the expected final value until the operation completes, and then it flips. Timing comes from a single down-counter loaded with a per-operation cycle count. These counts are parameters that stand in for the real millisecond and second delays.

The command sequencer drives the inputs. It pulses a program-done event together with bit 7 of the data being written, or a sector-erase or chip-erase start. It also strobes a status read each time the host reads during an operation, and it holds a bypass flag. At completion the block emits a one-cycle pulse. With that pulse it indicates whether the sequencer should return to the command-decode step (bypass active) or to plain read mode. A cancel input, driven by a reset command, abandons any running operation.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, status_o is 0x00, busy_o is 0 and done_o is 0.
- R2: An accepted sector-erase start sets status_o to 0x00 on the next cycle, and busy_o then stays high for exactly SEC_CYCLES cycles.
- R3: An accepted chip-erase start sets status_o to 0x00 on the next cycle, and busy_o then stays high for exactly CHIP_CYCLES cycles.
- R4: An accepted program-done event loads status_o with bits 6:0 all ones and bit 7 equal to the inverse of prog_d7_i. The result is 0x7F when prog_d7_i is 1 and 0xFF when it is 0. busy_o then stays high for exactly PROG_CYCLES cycles.
- R5: A status read strobe taken while busy_o is high inverts status_o bit 6 on the next cycle. A strobe taken while busy_o is low leaves status_o unchanged.
- R6: In the cycle busy_o falls at the end of an operation, status_o bit 7 is inverted, and done_o is high for exactly that one cycle.
- R7: While done_o is high, done_to_cmd_o equals the value bypass_i had in the cycle the count ran out. 1 means the sequencer returns to command decode, and 0 means it returns to read mode.
- R8: Start requests (program, sector erase, chip erase) that arrive while busy_o is high are ignored. They do not restart the count and do not alter status_o.
- R9: cancel_i clears status_o to 0x00 and busy_o to 0 on the next cycle, and no done_o pulse follows. cancel_i overrides any start request in the same cycle.
- R10: When several start requests arrive together while idle, chip erase wins over sector erase, and sector erase wins over program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cancel_i | input | 1 | Reset command: abandon any operation and clear status |
| prog_done_i | input | 1 | Pulse: a program write has been applied |
| prog_d7_i | input | 1 | Bit 7 of the programmed data, valid with prog_done_i |
| sec_erase_i | input | 1 | Pulse: begin a sector erase |
| chip_erase_i | input | 1 | Pulse: begin a chip erase |
| stat_rd_i | input | 1 | Pulse: the host read the status byte |
| bypass_i | input | 1 | Bypass command mode is active in the sequencer |
| status_o | output | 8 | Status byte returned to the host |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when an operation ends |
| done_to_cmd_o | output | 1 | With done_o: 1 = return to command decode, 0 = read mode |

## Verification
On every cycle, the assertions check the following local rules: cancel clears the status and busy, a read while busy flips bit 6, a read while idle leaves the byte alone, a completion pulse flips bit 7 and lasts one cycle, and a start is never loaded while the counter runs. Three properties need the bench's scenarios because they depend on counting or on combinations of inputs: the exact operation lengths, the priority among starts that arrive together, and the program status encoding for both data polarities. The bench reaches them with directed sequences and with a long random run compared against its own cycle model.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } fps_op_e;

  // Chip erase outranks sector erase, which outranks program.
  function automatic fps_op_e op_pick(input logic chip, input logic sect, input logic prog);
    if (chip)      return OP_CHIP;
    else if (sect) return OP_SECT;
    else if (prog) return OP_PROG;
    else           return OP_NONE;
  endfunction

  // Data-polling byte after a program: low bits set, bit 7 inverted from data.
  function automatic logic [7:0] prog_status(input logic d7);
    return {~d7, 7'h7F};
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             expire
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (cancel)          remain_q <= '0;
    else if (load)            remain_q <= load_val;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign active = (remain_q != '0);
  assign expire = (remain_q == CNT_W'(1));

  // R8
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !cancel |=> remain_q == $past(load_val));

endmodule

// File: rtl/fps_status_reg.sv
module fps_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       tgl6,
  input  logic       flip7,
  output logic [7:0] status
);

  logic [7:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 8'h00;
    else if (clr)   st_q <= 8'h00;
    else if (load)  st_q <= load_val;
    else            st_q <= st_q ^ {flip7, tgl6, 6'b000000};
  end

  assign status = st_q;

  // R4
  low_bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !load |=> st_q[5:0] == $past(st_q[5:0]));

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEC_CYCLES  = 24,
  parameter int CHIP_CYCLES = 60,
  parameter int PROG_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cancel,
  input  logic             prog_done,
  input  logic             prog_d7,
  input  logic             sec_erase,
  input  logic             chip_erase,
  input  logic             stat_rd,
  input  logic             bypass,
  input  logic             timer_active,
  input  logic             timer_expire,
  output logic             accept,
  output logic [CNT_W-1:0] load_val,
  output logic             st_clr,
  output logic             st_load,
  output logic [7:0]       st_val,
  output logic             st_tgl,
  output logic             st_flip,
  output logic             done,
  output logic             to_cmd
);

  fps_op_e op;
  logic    finish;
  logic    done_q;
  logic    to_cmd_q;

  function automatic logic [CNT_W-1:0] cycles_for(input fps_op_e o);
    case (o)
      OP_CHIP: return CNT_W'(CHIP_CYCLES);
      OP_SECT: return CNT_W'(SEC_CYCLES);
      OP_PROG: return CNT_W'(PROG_CYCLES);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    op       = op_pick(chip_erase, sec_erase, prog_done);
    accept   = !cancel && !timer_active && (op != OP_NONE);
    load_val = cycles_for(op);
    st_val   = (op == OP_PROG) ? prog_status(prog_d7) : 8'h00;
    finish   = timer_expire && !cancel;
  end

  assign st_clr  = cancel;
  assign st_load = accept;
  assign st_tgl  = timer_active && stat_rd && !cancel;
  assign st_flip = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      to_cmd_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) to_cmd_q <= bypass;
    end
  end

  assign done   = done_q;
  assign to_cmd = to_cmd_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expire && !cancel |=> to_cmd_q == $past(bypass));

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fps_pkg::*;
#(
  parameter int SEC_CYCLES  = 24,
  parameter int CHIP_CYCLES = 60,
  parameter int PROG_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cancel_i,
  input  logic       prog_done_i,
  input  logic       prog_d7_i,
  input  logic       sec_erase_i,
  input  logic       chip_erase_i,
  input  logic       stat_rd_i,
  input  logic       bypass_i,
  output logic [7:0] status_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       done_to_cmd_o
);

  localparam int MAX_CYCLES = max3(SEC_CYCLES, CHIP_CYCLES, PROG_CYCLES);
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  logic             timer_active;
  logic             timer_expire;
  logic             accept;
  logic [CNT_W-1:0] load_val;
  logic             st_clr;
  logic             st_load;
  logic [7:0]       st_val;
  logic             st_tgl;
  logic             st_flip;
  logic             any_start;

  assign any_start = prog_done_i || sec_erase_i || chip_erase_i;

  fps_ctrl #(
    .CNT_W       (CNT_W),
    .SEC_CYCLES  (SEC_CYCLES),
    .CHIP_CYCLES (CHIP_CYCLES),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cancel       (cancel_i),
    .prog_done    (prog_done_i),
    .prog_d7      (prog_d7_i),
    .sec_erase    (sec_erase_i),
    .chip_erase   (chip_erase_i),
    .stat_rd      (stat_rd_i),
    .bypass       (bypass_i),
    .timer_active (timer_active),
    .timer_expire (timer_expire),
    .accept       (accept),
    .load_val     (load_val),
    .st_clr       (st_clr),
    .st_load      (st_load),
    .st_val       (st_val),
    .st_tgl       (st_tgl),
    .st_flip      (st_flip),
    .done         (done_o),
    .to_cmd       (done_to_cmd_o)
  );

  fps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cancel   (cancel_i),
    .load     (accept),
    .load_val (load_val),
    .active   (timer_active),
    .expire   (timer_expire)
  );

  fps_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st_clr),
    .load     (st_load),
    .load_val (st_val),
    .tgl6     (st_tgl),
    .flip7    (st_flip),
    .status   (status_o)
  );

  assign busy_o = timer_active;

  // R9
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> status_o == 8'h00 && !busy_o && !done_o);

  // R5
  busy_read_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && stat_rd_i && !cancel_i |=> status_o[6] != $past(status_o[6]));

  // R5
  idle_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !cancel_i && !any_start |=> status_o == $past(status_o));

  // R6
  done_flips_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cancel_i && timer_expire |=> done_o && !busy_o && status_o[7] != $past(status_o[7]));

  // R8
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !cancel_i && !timer_expire |=> busy_o && status_o[7] == $past(status_o[7]));

endmodule

// File: tb/flash_status_poller_tb.sv
module flash_status_poller_tb;

  localparam int SEC  = 24;
  localparam int CHIP = 60;
  localparam int PROG = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cancel_i = 1'b0;
  logic       prog_done_i = 1'b0;
  logic       prog_d7_i = 1'b0;
  logic       sec_erase_i = 1'b0;
  logic       chip_erase_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic [7:0] status_o;
  logic       busy_o;
  logic       done_o;
  logic       done_to_cmd_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  flash_status_poller #(
    .SEC_CYCLES(SEC), .CHIP_CYCLES(CHIP), .PROG_CYCLES(PROG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cancel_i(cancel_i), .prog_done_i(prog_done_i),
    .prog_d7_i(prog_d7_i), .sec_erase_i(sec_erase_i), .chip_erase_i(chip_erase_i),
    .stat_rd_i(stat_rd_i), .bypass_i(bypass_i), .status_o(status_o),
    .busy_o(busy_o), .done_o(done_o), .done_to_cmd_o(done_to_cmd_o)
  );

  // ---------------- bench reference model ----------------
  logic [7:0] m_st;
  bit         m_busy, m_done, m_dtc;
  int         m_left;
  bit         cmp_en = 1'b0;

  function automatic logic [7:0] exp_prog(input logic d7);
    return d7 ? 8'h7F : 8'hFF;
  endfunction

  function automatic int exp_len(input logic chip, input logic sect);
    if (chip) return CHIP;
    if (sect) return SEC;
    return PROG;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 8'h00; m_busy = 0; m_done = 0; m_dtc = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (cancel_i) begin
        m_st = 8'h00; m_busy = 0; m_left = 0;
      end else if (m_busy) begin
        if (stat_rd_i) m_st[6] = ~m_st[6];
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_st[7] = ~m_st[7]; m_busy = 0; m_done = 1; m_dtc = bypass_i;
        end
      end else if (chip_erase_i || sec_erase_i || prog_done_i) begin
        m_st   = (chip_erase_i || sec_erase_i) ? 8'h00 : exp_prog(prog_d7_i);
        m_busy = 1;
        m_left = exp_len(chip_erase_i, sec_erase_i);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R5 status vs model", status_o, m_st);
      chk("R6 busy vs model", busy_o, m_busy);
      chk("R6 done vs model", done_o, m_done);
      if (m_done) chk("R7 return target vs model", done_to_cmd_o, m_dtc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    cancel_i = 0; prog_done_i = 0; sec_erase_i = 0; chip_erase_i = 0; stat_rd_i = 0;
  endtask

  // Count busy cycles after a start seen on the previous negedge; stops at the drop.
  task automatic wait_idle(output int n);
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      if (!busy_o) break;
      n++;
      tick();
    end
  endtask

  initial begin
    int n;
    bit saw_done;
    void'($urandom(32'h5EED_0C0F));
    repeat (3) tick();
    // R1
    chk("R1 status after reset", status_o, 8'h00);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 done after reset", done_o, 0);
    rst_n = 1; tick();
    cmp_en = 1;

    // R2 sector erase with bypass active
    bypass_i = 1; sec_erase_i = 1; tick(); clear_in();
    chk("R2 sector start status", status_o, 8'h00);
    chk("R2 sector start busy", busy_o, 1);
    stat_rd_i = 1; tick(); clear_in();
    chk("R5 read while busy toggles bit6", status_o, 8'h40);
    // R8 starts while busy are ignored
    chip_erase_i = 1; prog_done_i = 1; prog_d7_i = 1; tick(); clear_in();
    chk("R8 status after ignored start", status_o, 8'h40);
    chk("R8 busy after ignored start", busy_o, 1);
    wait_idle(n);
    chk("R2 sector length", n + 2, SEC);
    chk("R6 done at end", done_o, 1);
    chk("R6 bit7 inverted", status_o, 8'hC0);
    chk("R7 bypass return", done_to_cmd_o, 1);
    tick();
    chk("R6 done one cycle", done_o, 0);
    stat_rd_i = 1; tick(); clear_in();
    chk("R5 idle read ignored", status_o, 8'hC0);

    // R3 R10 all starts together, bypass off
    bypass_i = 0; chip_erase_i = 1; sec_erase_i = 1; prog_done_i = 1; prog_d7_i = 0;
    tick(); clear_in();
    chk("R10 chip wins status", status_o, 8'h00);
    wait_idle(n);
    chk("R3 R10 chip length", n, CHIP);
    chk("R7 read-mode return", done_to_cmd_o, 0);
    tick();

    // R10 sector beats program
    sec_erase_i = 1; prog_done_i = 1; prog_d7_i = 1; tick(); clear_in();
    chk("R10 sector over program status", status_o, 8'h00);
    wait_idle(n);
    chk("R10 sector over program length", n, SEC);
    tick();

    // R4 program, both data polarities
    prog_done_i = 1; prog_d7_i = 1; tick(); clear_in();
    chk("R4 program d7=1 status", status_o, 8'h7F);
    wait_idle(n);
    chk("R4 program length", n, PROG);
    chk("R4 program final", status_o, 8'hFF);
    tick();
    prog_done_i = 1; prog_d7_i = 0; tick(); clear_in();
    chk("R4 program d7=0 status", status_o, 8'hFF);
    wait_idle(n);
    chk("R4 program d7=0 final", status_o, 8'h7F);
    tick();

    // R9 cancel mid operation
    sec_erase_i = 1; tick(); clear_in();
    repeat (5) tick();
    cancel_i = 1; tick(); clear_in();
    chk("R9 cancel status", status_o, 8'h00);
    chk("R9 cancel busy", busy_o, 0);
    saw_done = 0;
    for (int k = 0; k < SEC + 4; k++) begin
      if (done_o) saw_done = 1;
      tick();
    end
    chk("R9 no done after cancel", saw_done, 0);
    cancel_i = 1; chip_erase_i = 1; tick(); clear_in();
    chk("R9 cancel beats start", busy_o, 0);

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      cancel_i     = ($urandom_range(0, 299) == 0);
      chip_erase_i = ($urandom_range(0, 79) == 0);
      sec_erase_i  = ($urandom_range(0, 39) == 0);
      prog_done_i  = ($urandom_range(0, 14) == 0);
      prog_d7_i    = $urandom_range(0, 1);
      stat_rd_i    = ($urandom_range(0, 2) == 0);
      bypass_i     = $urandom_range(0, 1);
      tick();
    end
    clear_in();
    repeat (2) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule